// File: doc/BRIEF.md
# Crosspoint Routing Configuration Store

This block keeps the routing state for a crosspoint matrix of 16 inputs by 8 outputs. For each output it stores a 4-bit input select and an enable bit. It presents the state as one packed select bus and one enable vector, which the switch fabric decodes. The state sits in two ranks. A loading rank is written by the host. A transparent holding rank drives the matrix, so a new routing can be staged completely and then applied all at once.

The loading rank accepts data in one of two ways, both on the falling clock edge. In serial mode it is one long shift register, and its far end appears on a serial output so several blocks can be chained. In parallel mode one output's entry is written per edge through an address and a 5-bit data word. An active-low chip enable gates both loading and the holding rank. An asynchronous active-low reset clears both ranks, which leaves every output disabled.

Top module: `xbar_cfg`

## Requirements
- R1: While `rstN` is low, both ranks clear asynchronously with no clock edge needed. After that, every `routeEn` bit and every `routeSel` field reads 0, and so does `serOut`.
- R2: With `ceN` low and `parSel` low, each falling edge of `clk` shifts `serIn` into the loading rank. The serial frame is 40 bits. It is sent output 7 first and output 0 last. Within each output's 5 bits, the enable comes first, then the select from MSB to LSB.
- R3: `serOut` always shows the far end of the loading rank. It therefore repeats, in order, the bits shifted in 40 falling edges earlier.
- R4: With `ceN` low and `parSel` high, a falling edge writes `dataIn` into the entry addressed by `addr`. `dataIn[4]` is the enable and `dataIn[3:0]` is the input select. All other entries keep their values.
- R5: While `ceN` is high, neither shifting nor parallel writes take place, and the holding rank does not follow the loading rank even if `updateN` is low.
- R6: While `updateN` and `ceN` are both low, the outputs follow the loading rank transparently, and they change after every edge that loads it.
- R7: While `updateN` is high, the outputs hold their value as the loading rank changes.
- R8: For output k, the input select appears on `routeSel[4k+3:4k]` and the enable on `routeEn[k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Load clock; acts on its falling edge |
| rstN | input | 1 | Asynchronous reset, active low; disables all outputs |
| ceN | input | 1 | Chip enable, active low; gates loading and the holding rank |
| updateN | input | 1 | Holding rank transparent when low, holds when high |
| parSel | input | 1 | 0 selects serial loading, 1 selects parallel loading |
| serIn | input | 1 | Serial configuration data in |
| serOut | output | 1 | Far end of the shift chain, for cascading |
| addr | input | 3 | Parallel mode: output being written |
| dataIn | input | 5 | Parallel mode: bit 4 enable, bits 3:0 input select |
| routeSel | output | 32 | Input select per output, 4 bits each |
| routeEn | output | 8 | Enable per output |

## Verification
The bench builds the block with its default sizes: 16 inputs and 8 outputs, which gives a 40-bit frame and a 3-bit address. At these sizes every address is written from a vector table. The select extremes 0 and 15 appear, and two complete serial frames pass through, so the second one pushes the first out of `serOut` bit by bit. Asynchronous reset is applied between clock edges, and the gating of `ceN` over the holding rank is checked separately from its gating over loading.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // Strobes from control to the datapath
  typedef struct packed {
    logic shiftEn;  // shift loading rank by one
    logic writeEn;  // write one addressed entry
    logic passEn;   // holding rank transparent
  } xbarStrobes_t;
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
(
  input  logic         ceN,
  input  logic         parSel,
  input  logic         updateN,
  output xbarStrobes_t strb
);
  logic chipOn;

  assign chipOn       = ~ceN;
  assign strb.shiftEn = chipOn & ~parSel;
  assign strb.writeEn = chipOn & parSel;
  assign strb.passEn  = chipOn & ~updateN;
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import xbar_pkg::*;
#(
  parameter int NUM_OUT = 8,
  parameter int SEL_W   = 4,
  parameter int ADDR_W  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  xbarStrobes_t             strb,
  input  logic                     serIn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [SEL_W:0]           dataIn,
  output logic                     serOut,
  output logic [NUM_OUT*SEL_W-1:0] routeSel,
  output logic [NUM_OUT-1:0]       routeEn
);
  localparam int ENTRY_W = SEL_W + 1;
  localparam int FRAME_W = NUM_OUT * ENTRY_W;

  logic [FRAME_W-1:0] rank1;
  logic [FRAME_W-1:0] rank1Next;
  logic [FRAME_W-1:0] rank2;

  // Next value of the loading rank
  always_comb begin
    rank1Next = rank1;
    if (strb.shiftEn) begin
      rank1Next = {rank1[FRAME_W-2:0], serIn};
    end else if (strb.writeEn) begin
      for (int k = 0; k < NUM_OUT; k++) begin
        if (addr == ADDR_W'(k)) rank1Next[k*ENTRY_W +: ENTRY_W] = dataIn;
      end
    end
  end

  // Loading rank: falling edge, asynchronous clear
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) rank1 <= '0;
    else       rank1 <= rank1Next;
  end

  // Holding rank: transparent while passEn, asynchronous clear
  always_latch begin
    if (!rstN)            rank2 <= '0;
    else if (strb.passEn) rank2 <= rank1;
  end

  assign serOut = rank1[FRAME_W-1];

  for (genvar k = 0; k < NUM_OUT; k++) begin : gOut
    assign routeSel[k*SEL_W +: SEL_W] = rank2[k*ENTRY_W +: SEL_W];
    assign routeEn[k]                 = rank2[k*ENTRY_W + SEL_W];

    AST_WRITE_HIT: assert property (@(negedge clk) disable iff (!rstN)
      (strb.writeEn && !strb.shiftEn && addr == ADDR_W'(k)) |=>
        rank1[k*ENTRY_W +: ENTRY_W] == $past(dataIn)); // R4
    AST_WRITE_MISS: assert property (@(negedge clk) disable iff (!rstN)
      (strb.writeEn && addr != ADDR_W'(k)) |=>
        $stable(rank1[k*ENTRY_W +: ENTRY_W])); // R4
  end

  AST_RESET_CLEAR: assert property (@(negedge clk)
    !rstN |-> (rank1 == '0 && routeEn == '0 && routeSel == '0)); // R1
  AST_SHIFT_STEP: assert property (@(negedge clk) disable iff (!rstN)
    strb.shiftEn |=> (rank1[FRAME_W-1:1] == $past(rank1[FRAME_W-2:0]) &&
                      rank1[0] == $past(serIn))); // R2
  AST_IDLE_HOLD: assert property (@(negedge clk) disable iff (!rstN)
    (!strb.shiftEn && !strb.writeEn) |=> $stable(rank1)); // R5
  AST_PASS_FOLLOW: assert property (@(negedge clk) disable iff (!rstN)
    strb.passEn |-> rank2 == rank1); // R6
endmodule

// File: rtl/xbar_cfg.sv
module xbar_cfg
  import xbar_pkg::*;
#(
  parameter int NUM_IN  = 16,
  parameter int NUM_OUT = 8,
  localparam int SEL_W  = $clog2(NUM_IN),
  localparam int ADDR_W = $clog2(NUM_OUT)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ceN,
  input  logic                     updateN,
  input  logic                     parSel,
  input  logic                     serIn,
  output logic                     serOut,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [SEL_W:0]           dataIn,
  output logic [NUM_OUT*SEL_W-1:0] routeSel,
  output logic [NUM_OUT-1:0]       routeEn
);
  xbarStrobes_t strb;

  xbar_ctrl uCtrl (
    .ceN     (ceN),
    .parSel  (parSel),
    .updateN (updateN),
    .strb    (strb)
  );

  xbar_datapath #(
    .NUM_OUT (NUM_OUT),
    .SEL_W   (SEL_W),
    .ADDR_W  (ADDR_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .serIn    (serIn),
    .addr     (addr),
    .dataIn   (dataIn),
    .serOut   (serOut),
    .routeSel (routeSel),
    .routeEn  (routeEn)
  );
endmodule

// File: tb/tb_xbar_cfg.sv
module tb_xbar_cfg;
  localparam int NO = 8;
  localparam int SW = 4;
  localparam int EW = SW + 1;
  localparam int FW = NO * EW;

  logic clk = 1'b0;
  logic rstN = 1'b0, ceN = 1'b1, updateN = 1'b1, parSel = 1'b0, serIn = 1'b0;
  logic [2:0] addr = '0;
  logic [SW:0] dataIn = '0;
  logic serOut;
  logic [NO*SW-1:0] routeSel;
  logic [NO-1:0] routeEn;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [FW-1:0] mRank1 = '0, mOut = '0;

  // Vector table: {addr[2:0], enable, select[3:0]}
  localparam logic [7:0] PAR_VEC [8] = '{
    8'b101_1_1111, 8'b000_1_0000, 8'b111_0_1010, 8'b010_1_0011,
    8'b110_1_1100, 8'b001_0_0110, 8'b100_1_1001, 8'b011_1_0101
  };

  xbar_cfg dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .updateN(updateN), .parSel(parSel),
    .serIn(serIn), .serOut(serOut), .addr(addr), .dataIn(dataIn),
    .routeSel(routeSel), .routeEn(routeEn)
  );

  always #5 clk = ~clk;

  // Expected ports {routeEn, routeSel} from a frame image
  function automatic logic [NO*EW-1:0] expPorts(input logic [FW-1:0] m);
    logic [NO-1:0] en;
    logic [NO*SW-1:0] sel;
    for (int k = 0; k < NO; k++) begin
      en[k] = m[k*EW + SW];
      sel[k*SW +: SW] = m[k*EW +: SW];
    end
    return {en, sel};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkOut(input string req);
    chk(req, {24'd0, routeEn, routeSel}, {24'd0, expPorts(mOut)});
  endtask

  task automatic parWrite(input logic [2:0] a, input logic [SW:0] d);
    parSel = 1'b1; ceN = 1'b0; addr = a; dataIn = d;
    @(negedge clk); #1;
    mRank1[a*EW +: EW] = d;
    if (!updateN) mOut = mRank1;
    ceN = 1'b1;
  endtask

  task automatic serShift(input logic b);
    parSel = 1'b0; ceN = 1'b0; serIn = b;
    @(negedge clk); #1;
    mRank1 = {mRank1[FW-2:0], b};
    if (!updateN) mOut = mRank1;
    ceN = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] frameF, frameG, seen;
    for (int k = 0; k < NO; k++) begin
      frameF[k*EW +: EW] = {k[0], 4'(15 - 2 * k)};
      frameG[k*EW +: EW] = {~k[0], 4'(k)};
    end

    // R1: reset state before any clock edge
    #3;
    chkOut("R1 reset outputs");
    chk("R1 reset serOut", 64'(serOut), 64'd0);
    @(negedge clk); #1;
    rstN = 1'b1;

    // R4 R8 R6: table of parallel writes with the holding rank open
    updateN = 1'b0;
    for (int i = 0; i < 8; i++) begin
      parWrite(PAR_VEC[i][7:5], PAR_VEC[i][4:0]);
      chkOut("R4 R8 parallel write");
    end
    chk("R8 output5 enable", 64'(routeEn[5]), 64'd1);
    chk("R8 output5 select", 64'(routeSel[23:20]), 64'hf);

    // R5: with ceN high, write and shift attempts are ignored
    parSel = 1'b1; addr = 3'd2; dataIn = 5'b0_1110;
    @(negedge clk); #1;
    parSel = 1'b0; serIn = 1'b1;
    @(negedge clk); #1;
    chkOut("R5 ceN high ignores loading");
    ceN = 1'b0; #2;
    chkOut("R5 loading rank untouched");
    ceN = 1'b1;

    // R7: outputs hold while updateN high
    updateN = 1'b1;
    parWrite(3'd5, 5'b0_0111);
    chkOut("R7 hold during write");
    // R5: ceN high keeps the holding rank closed
    updateN = 1'b0; #2;
    chkOut("R5 ceN gates update");
    ceN = 1'b0; #2;
    mOut = mRank1;
    chkOut("R6 open on ceN low");
    ceN = 1'b1; updateN = 1'b1;

    // R2 R7: serial frame shifted in while held
    for (int i = FW - 1; i >= 0; i--) serShift(frameF[i]);
    chkOut("R7 hold during shift");
    ceN = 1'b0; updateN = 1'b0; #2;
    mOut = mRank1;
    chk("R2 frame order", {24'd0, routeEn, routeSel}, {24'd0, expPorts(frameF)});
    chk("R2 output7 enable first", 64'(routeEn[7]), 64'(frameF[FW-1]));
    ceN = 1'b1;

    // R3 R6: second frame pushes the first out of serOut
    for (int i = FW - 1; i >= 0; i--) begin
      seen[i] = serOut;
      serShift(frameG[i]);
      if (i == 30 || i == 7) chkOut("R6 follows each shift");
    end
    chk("R3 daisy-chain out", 64'(seen), 64'(frameF));
    chk("R2 second frame", {24'd0, routeEn, routeSel}, {24'd0, expPorts(frameG)});

    // R1: asynchronous reset between edges
    @(posedge clk); #1;
    rstN = 1'b0; #2;
    mRank1 = '0; mOut = '0;
    chkOut("R1 async reset outputs");
    chk("R1 async reset serOut", 64'(serOut), 64'd0);
    @(negedge clk); #1;
    rstN = 1'b1;
    ceN = 1'b0; updateN = 1'b0; #2;
    chkOut("R1 loading rank cleared");
    ceN = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule